// File: doc/BRIEF.md
# Delay-Line Calibration and Phase Tuner

This block sets up a receive-clock delay line in two passes. In the first pass it calibrates the delay unit. It loads unit values in increasing order, with the select fixed at a calibration tap and the sampler switched on. For each unit it waits for the line to report a measured length, and it keeps the first unit whose length is usable. The position of the highest set bit of that length gives the largest usable output tap.

In the second pass it sweeps every tap from zero up to that maximum. At each tap it asks an external agent to run a tuning trial and gets back a pass or fail result. It tracks the longest unbroken run of passing taps and finally programs the tap at the centre of that run.

One `done` pulse marks the end of a run, together with a result code. After a successful run the chosen unit, the maximum tap and the final tap stay on the result outputs.

Top module: `dly_tuner`

## Requirements
- R1: After reset, `done`, `trial_req`, `dl_load` and `dl_en` are low, and `status` is 2'b00.
- R2: After `start`, unit values are loaded one at a time, starting at 0 and rising by one. Each unit load pulses `dl_load` with `dl_sel` = CAL_SEL (default 12) and with both `dl_smp_en` and `dl_en` high.
- R3: If `dl_len_vld` is not seen within TIMEOUT_CYC cycles of waiting after a unit load, the tuner moves on to the next unit value.
- R4: The 12-bit length is accepted only when it is nonzero and below 2048, that is when bit 11 is clear. A rejected length moves the tuner on to the next unit value.
- R5: If no unit value from 0 to 127 is accepted, `done` pulses with `status` = 2'b10 (calibration failure) after exactly 128 unit loads.
- R6: The maximum tap (`res_max_tap`) equals the index of the most significant set bit of the accepted length. `res_unit` holds the accepted unit value.
- R7: The sweep runs exactly one trial per tap, from 0 up to the maximum tap in increasing order. During a trial `dl_sel` holds the tap, `dl_smp_en` is low and `dl_en` is high. `trial_req` stays high and `dl_sel` stays stable until `trial_ack` arrives.
- R8: A failed trial resets the current run length to zero. A run only replaces the best run when it is strictly longer, so among runs of equal length the one that ends first wins.
- R9: On success, `status` = 2'b01. The final tap (`res_phase`), which is also left on `dl_sel`, equals the best run's ending tap minus half of its length, rounded down.
- R10: If no tap passes, `done` pulses with `status` = 2'b11 (no tuning point) and `dl_en` is cleared.
- R11: `done` is high for exactly one cycle per run. The result outputs keep their values after the pulse.
- R12: Every configuration write, whether for calibration, a sweep step or the final tap, pulses `dl_load` while `dl_smp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins calibration and sweep when idle |
| dl_unit | output | 7 | Delay unit value driven to the line |
| dl_sel | output | 4 | Output tap select driven to the line |
| dl_en | output | 1 | Delay line enable |
| dl_smp_en | output | 1 | Length sampler enable |
| dl_load | output | 1 | Configuration write strobe |
| dl_len | input | 12 | Measured line length |
| dl_len_vld | input | 1 | Measured length is valid |
| trial_req | output | 1 | Request a tuning trial at the current tap |
| trial_ack | input | 1 | Trial finished (one-cycle pulse) |
| trial_pass | input | 1 | Trial result, sampled with `trial_ack` |
| done | output | 1 | One-cycle end-of-run strobe |
| status | output | 2 | 00 none, 01 ok, 10 calibration failure, 11 no tuning point |
| res_unit | output | 7 | Accepted unit value |
| res_max_tap | output | 4 | Largest usable tap |
| res_phase | output | 4 | Final programmed tap |

## Verification
The acknowledgement of the last tap's trial triggers three things in the same cycle: the run-length update, the end-of-sweep decision, and the computation of the centred tap. One case makes that final trial extend a run past the previous best. The bench then checks that the programmed tap reflects the new run and not the stale one.

A second case contrasts the all-fail sweep, which must report no tuning point, with a single passing tap at maximum tap zero. Expected taps are worked out by a brute-force search over all intervals of the pass pattern.

// File: rtl/dly_tuner_pkg.sv
package dly_tuner_pkg;
    typedef enum logic [7:0] {
        ST_IDLE      = 8'h01,
        ST_CAL_SET   = 8'h02,
        ST_CAL_WAIT  = 8'h04,
        ST_SWP_SET   = 8'h08,
        ST_SWP_TRIAL = 8'h10,
        ST_FIN_SET   = 8'h20,
        ST_DONE      = 8'h40,
        ST_ERR       = 8'h80
    } tuner_state_e;

    typedef enum logic [1:0] {
        RES_NONE     = 2'b00,
        RES_OK       = 2'b01,
        RES_CAL_FAIL = 2'b10,
        RES_NO_POINT = 2'b11
    } tuner_result_e;
endpackage

// File: rtl/dly_tuner_msb.sv
module dly_tuner_msb #(
    parameter int W  = 12,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dly_tuner_run.sv
module dly_tuner_run #(
    parameter int PW = 4,
    parameter int RW = 5
) (
    input  logic          pass,
    input  logic [PW-1:0] phase,
    input  logic [RW-1:0] cur,
    input  logic [RW-1:0] best,
    input  logic [PW-1:0] best_end,
    output logic [RW-1:0] cur_n,
    output logic [RW-1:0] best_n,
    output logic [PW-1:0] end_n
);
    logic [RW-1:0] grown;

    always_comb begin
        grown  = cur + 1'b1;
        cur_n  = pass ? grown : '0;
        best_n = best;
        end_n  = best_end;
        if (pass && (grown > best)) begin
            best_n = grown;
            end_n  = phase;
        end
    end
endmodule

// File: rtl/dly_tuner.sv
module dly_tuner #(
    parameter int UNIT_W      = 7,
    parameter int LEN_W       = 12,
    parameter int CAL_SEL     = 12,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [UNIT_W-1:0] dl_unit,
    output logic [3:0]        dl_sel,
    output logic              dl_en,
    output logic              dl_smp_en,
    output logic              dl_load,
    input  logic [LEN_W-1:0]  dl_len,
    input  logic              dl_len_vld,
    output logic              trial_req,
    input  logic              trial_ack,
    input  logic              trial_pass,
    output logic              done,
    output logic [1:0]        status,
    output logic [UNIT_W-1:0] res_unit,
    output logic [3:0]        res_max_tap,
    output logic [3:0]        res_phase
);
    import dly_tuner_pkg::*;

    localparam int SEL_W = 4;
    localparam int RUN_W = SEL_W + 1;
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [UNIT_W-1:0] UNIT_LAST = '1;
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        tuner_state_e      state;
        logic [UNIT_W-1:0] unit;
        logic [SEL_W-1:0]  sel;
        logic [SEL_W-1:0]  phase;
        logic [SEL_W-1:0]  maxtap;
        logic [SEL_W-1:0]  fin;
        logic [RUN_W-1:0]  cur;
        logic [RUN_W-1:0]  best;
        logic [SEL_W-1:0]  bend;
        logic [TMR_W-1:0]  tmr;
        logic              en;
        tuner_result_e     status;
    } regs_t;

    regs_t r_q, r_d;

    logic [SEL_W-1:0] len_msb;
    logic [RUN_W-1:0] run_cur, run_best;
    logic [SEL_W-1:0] run_end, centre;
    logic             accept, advance;

    dly_tuner_msb #(.W(LEN_W), .IW(SEL_W)) u_msb (
        .vec (dl_len),
        .idx (len_msb)
    );

    dly_tuner_run #(.PW(SEL_W), .RW(RUN_W)) u_run (
        .pass     (trial_pass),
        .phase    (r_q.phase),
        .cur      (r_q.cur),
        .best     (r_q.best),
        .best_end (r_q.bend),
        .cur_n    (run_cur),
        .best_n   (run_best),
        .end_n    (run_end)
    );

    always_comb begin
        r_d     = r_q;
        advance = 1'b0;
        accept  = (dl_len != '0) && !dl_len[LEN_W-1];
        centre  = run_end - SEL_W'(run_best >> 1);
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state  = ST_CAL_SET;
                    r_d.unit   = '0;
                    r_d.sel    = SEL_W'(CAL_SEL);
                    r_d.en     = 1'b1;
                    r_d.status = RES_NONE;
                end
            end
            ST_CAL_SET: begin
                r_d.state = ST_CAL_WAIT;
                r_d.tmr   = '0;
            end
            ST_CAL_WAIT: begin
                if (dl_len_vld) begin
                    if (accept) begin
                        r_d.state  = ST_SWP_SET;
                        r_d.maxtap = len_msb;
                        r_d.phase  = '0;
                        r_d.sel    = '0;
                        r_d.cur    = '0;
                        r_d.best   = '0;
                        r_d.bend   = '0;
                    end else begin
                        advance = 1'b1;
                    end
                end else if (r_q.tmr == TMR_LAST) begin
                    advance = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_SWP_SET: r_d.state = ST_SWP_TRIAL;
            ST_SWP_TRIAL: begin
                if (trial_ack) begin
                    r_d.cur  = run_cur;
                    r_d.best = run_best;
                    r_d.bend = run_end;
                    if (r_q.phase != r_q.maxtap) begin
                        r_d.phase = r_q.phase + 1'b1;
                        r_d.sel   = r_q.phase + 1'b1;
                        r_d.state = ST_SWP_SET;
                    end else if (run_best == '0) begin
                        r_d.state  = ST_ERR;
                        r_d.status = RES_NO_POINT;
                        r_d.en     = 1'b0;
                    end else begin
                        r_d.state = ST_FIN_SET;
                        r_d.sel   = centre;
                        r_d.fin   = centre;
                    end
                end
            end
            ST_FIN_SET: begin
                r_d.state  = ST_DONE;
                r_d.status = RES_OK;
            end
            ST_DONE, ST_ERR: r_d.state = ST_IDLE;
            default:         r_d.state = ST_IDLE;
        endcase
        if (advance) begin
            if (r_q.unit == UNIT_LAST) begin
                r_d.state  = ST_ERR;
                r_d.status = RES_CAL_FAIL;
                r_d.en     = 1'b0;
            end else begin
                r_d.unit  = r_q.unit + 1'b1;
                r_d.state = ST_CAL_SET;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.status <= RES_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dl_unit     = r_q.unit;
    assign dl_sel      = r_q.sel;
    assign dl_en       = r_q.en;
    assign dl_load     = (r_q.state == ST_CAL_SET) || (r_q.state == ST_SWP_SET)
                      || (r_q.state == ST_FIN_SET);
    assign dl_smp_en   = dl_load || (r_q.state == ST_CAL_WAIT);
    assign trial_req   = (r_q.state == ST_SWP_TRIAL);
    assign done        = (r_q.state == ST_DONE) || (r_q.state == ST_ERR);
    assign status      = r_q.status;
    assign res_unit    = r_q.unit;
    assign res_max_tap = r_q.maxtap;
    assign res_phase   = r_q.fin;
endmodule

// File: rtl/dly_tuner_chk.sv
module dly_tuner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trial_req,
    input logic       trial_ack,
    input logic [3:0] dl_sel,
    input logic       dl_smp_en,
    input logic       dl_en,
    input logic       dl_load,
    input logic       done,
    input logic [1:0] status,
    input logic [3:0] res_phase,
    input logic [3:0] res_max_tap
);
    assert_trial_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req |-> (!dl_smp_en && dl_en));

    assert_trial_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_req && !trial_ack) |=> (trial_req && $stable(dl_sel)));

    assert_one_trial_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_req && trial_ack) |=> !trial_req);

    assert_load_sampler_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dl_load |-> dl_smp_en);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'b00));

    assert_phase_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'b01) |-> (res_phase <= res_max_tap));

    assert_fail_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[1]) |-> !dl_en);
endmodule

bind dly_tuner dly_tuner_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trial_req   (trial_req),
    .trial_ack   (trial_ack),
    .dl_sel      (dl_sel),
    .dl_smp_en   (dl_smp_en),
    .dl_en       (dl_en),
    .dl_load     (dl_load),
    .done        (done),
    .status      (status),
    .res_phase   (res_phase),
    .res_max_tap (res_max_tap)
);

// File: tb/dly_tuner_tb.sv
module dly_tuner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  dl_unit;
    logic [3:0]  dl_sel;
    logic        dl_en, dl_smp_en, dl_load;
    logic [11:0] dl_len = '0;
    logic        dl_len_vld = 1'b0;
    logic        trial_req;
    logic        trial_ack = 1'b0;
    logic        trial_pass = 1'b0;
    logic        done;
    logic [1:0]  status;
    logic [6:0]  res_unit;
    logic [3:0]  res_max_tap, res_phase;

    always #5 clk = ~clk;

    dly_tuner u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dl_unit(dl_unit), .dl_sel(dl_sel), .dl_en(dl_en),
        .dl_smp_en(dl_smp_en), .dl_load(dl_load),
        .dl_len(dl_len), .dl_len_vld(dl_len_vld),
        .trial_req(trial_req), .trial_ack(trial_ack), .trial_pass(trial_pass),
        .done(done), .status(status), .res_unit(res_unit),
        .res_max_tap(res_max_tap), .res_phase(res_phase)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [11:0] len_tab [128];
    bit          resp_tab [128];
    logic [15:0] pass_mask;

    int cal_loads, cal_bad, trials, trial_bad, load_bad, wcnt, lcnt;
    int cur_unit;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // delay-line model and trial responder, both acting at the falling edge
    always @(negedge clk) begin
        if (dl_load) begin
            if (!dl_smp_en) load_bad++;
            if (dl_sel == 4'd12) begin
                if (dl_unit != 7'(cal_loads) || !dl_en) cal_bad++;
                cal_loads++;
            end
            dl_len_vld = 1'b0;
            lcnt = 0;
            cur_unit = int'(dl_unit);
        end else if (dl_smp_en && !dl_len_vld && resp_tab[cur_unit]) begin
            lcnt++;
            if (lcnt == 3) begin
                dl_len_vld = 1'b1;
                dl_len = len_tab[cur_unit];
            end
        end
        if (trial_ack) begin
            trial_ack = 1'b0;
        end else if (trial_req) begin
            wcnt++;
            if (wcnt == 2) begin
                wcnt = 0;
                if (dl_sel != 4'(trials) || dl_smp_en || !dl_en) trial_bad++;
                trials++;
                trial_pass = pass_mask[dl_sel];
                trial_ack = 1'b1;
            end
        end
    end

    task automatic clear_cfg();
        for (int u = 0; u < 128; u++) begin
            len_tab[u] = '0;
            resp_tab[u] = 1'b1;
        end
        pass_mask = '0;
    endtask

    task automatic run_case(input string name);
        int exp_unit, exp_max, best, bend, exp_fin, cyc, exp_status, exp_loads;
        bit ok_run, timed_out;
        logic [1:0] st_hold;
        logic [3:0] ph_hold;
        exp_unit = -1;
        for (int u = 0; u < 128; u++) begin
            if (exp_unit < 0 && resp_tab[u] && len_tab[u] != 0 && len_tab[u] < 12'd2048)
                exp_unit = u;
        end
        exp_max = 0;
        if (exp_unit >= 0) begin
            for (int b = 0; b < 12; b++) if (len_tab[exp_unit][b]) exp_max = b;
        end
        best = 0; bend = 0;
        for (int e = 0; e <= exp_max; e++) begin
            for (int s = 0; s <= e; s++) begin
                ok_run = 1'b1;
                for (int k = s; k <= e; k++) if (!pass_mask[k]) ok_run = 1'b0;
                if (ok_run && (e - s + 1) > best) begin
                    best = e - s + 1;
                    bend = e;
                end
            end
        end
        exp_fin = bend - best / 2;
        exp_status = (exp_unit < 0) ? 2 : (best == 0) ? 3 : 1;
        exp_loads = (exp_unit < 0) ? 128 : exp_unit + 1;

        cal_loads = 0; cal_bad = 0; trials = 0; trial_bad = 0; load_bad = 0; wcnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0; timed_out = 1'b0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin timed_out = 1'b1; break; end
        end
        chk(!timed_out, {"R11 watchdog ", name}, cyc, 0);
        chk(status == 2'(exp_status), {"R5/R9/R10 status ", name}, int'(status), exp_status);
        chk(cal_loads == exp_loads && cal_bad == 0, {"R2 R3 R4 unit loads ", name},
            cal_loads, exp_loads);
        chk(load_bad == 0, {"R12 load sampler ", name}, load_bad, 0);
        if (exp_unit >= 0) begin
            chk(res_unit == 7'(exp_unit), {"R4 unit ", name}, int'(res_unit), exp_unit);
            chk(res_max_tap == 4'(exp_max), {"R6 max tap ", name}, int'(res_max_tap), exp_max);
            chk(trials == exp_max + 1 && trial_bad == 0, {"R7 trials ", name},
                trials, exp_max + 1);
        end
        if (exp_status == 1) begin
            chk(res_phase == 4'(exp_fin), {"R8 R9 final tap ", name}, int'(res_phase), exp_fin);
            chk(dl_sel == 4'(exp_fin) && dl_en, {"R9 line tap ", name}, int'(dl_sel), exp_fin);
        end else begin
            chk(!dl_en, {"R10 enable cleared ", name}, int'(dl_en), 0);
        end
        st_hold = status; ph_hold = res_phase;
        @(negedge clk);
        chk(!done, {"R11 pulse ", name}, int'(done), 0);
        repeat (3) @(negedge clk);
        chk(status == st_hold && res_phase == ph_hold, {"R11 hold ", name},
            int'(status), int'(st_hold));
    endtask

    initial begin
        clear_cfg();
        cur_unit = 0;
        repeat (3) @(negedge clk);
        chk(!done && !trial_req && !dl_en && !dl_load, "R1 reset outputs",
            int'({done, trial_req, dl_en, dl_load}), 0);
        chk(status == 2'b00, "R1 reset status", int'(status), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        clear_cfg(); len_tab[0] = 12'h400; pass_mask = 16'h00F8;
        run_case("mid window");

        clear_cfg(); len_tab[1] = 12'h800; resp_tab[2] = 1'b0; len_tab[2] = 12'h010;
        len_tab[3] = 12'h01F; pass_mask = 16'h001B;
        run_case("reject, timeout, tie");

        clear_cfg(); len_tab[0] = 12'h001; pass_mask = 16'h0001;
        run_case("single tap");

        clear_cfg(); len_tab[0] = 12'h0A0; pass_mask = 16'h0000;
        run_case("no pass");

        clear_cfg();
        for (int u = 0; u < 128; u++) begin
            len_tab[u] = 12'hFFF;
            resp_tab[u] = (u % 2) == 0;
        end
        run_case("calibration fail");

        clear_cfg(); len_tab[5] = 12'h0FF; pass_mask = 16'h00FF;
        run_case("all pass");

        clear_cfg(); resp_tab[0] = 1'b0; resp_tab[1] = 1'b0; len_tab[2] = 12'h1C0;
        pass_mask = 16'h01E1;
        run_case("best on last tap");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule